// File: doc/BRIEF.md
# Transmit Byte Queue with Selectable Request Trigger

This block is a four-entry, byte-wide queue placed between a processor or DMA write port and the shift register of a serial transmitter. Each accepted write stores one byte. Each load pulse from the shift register removes the oldest byte. The byte at the head of the queue is always visible on the read-data output.

A trigger-select bit picks one of two rules for the transmit request, which drives both a level interrupt and an active-low DMA request:

- With the bit at 1, the request asks for data only when the queue is completely empty.
- With the bit at 0, the request asks for data whenever the write-side slot has room.

Both reset paths force the bit back to 1. A separate status bit always shows whether another write can be accepted. After every write cycle, the DMA request is forced inactive for one clock. This gives a downstream edge detector one falling edge per transferred byte.

Top module: `txq_top`

## Requirements
- R1: The queue holds up to 4 bytes. `head_data` shows the oldest stored byte. A `load_pulse` while bytes are stored removes it, so bytes leave in the order they were written. A write and a load in the same cycle are both performed.
- R2: The trigger-select bit is 1 after `rst_n` is low at a clock edge, and 1 after a cycle with `sw_reset` high. `sel_we` writes `sel_bit` into it. `sw_reset` also empties the queue and takes precedence over a write in the same cycle.
- R3: `slot_free` is 1 exactly when fewer than 4 bytes are stored, whatever the trigger-select bit is.
- R4: `tx_irq` is 1 when the trigger holds and 0 otherwise. The trigger is "0 bytes stored" when the select bit is 1, and "fewer than 4 bytes stored" when it is 0. The level follows the stored count from the cycle after the write or load that changes it.
- R5: A write while 4 bytes are stored is dropped and leaves the contents unchanged. It sets `overflow`, which stays 1 until `rst_n` reset; `sw_reset` does not clear it.
- R6: A `load_pulse` while the queue is empty removes nothing. It makes `underrun` 1 for the single following cycle.
- R7: `dma_req_n` is 1 in the cycle after any cycle with `wr_en` high. In every other cycle it is the inverse of the trigger from R4.
- R8: When the select bit is 0, each separated write that leaves room in the queue gives `dma_req_n` one high pulse followed by a return low, which is one falling edge per byte. The write that fills the queue leaves it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| sw_reset | input | 1 | Software reset command: sets the select bit to 1 and flushes the queue |
| sel_we | input | 1 | Write strobe for the trigger-select bit |
| sel_bit | input | 1 | New trigger-select value (1 = fully empty, 0 = room available) |
| wr_en | input | 1 | Byte write strobe from processor or DMA |
| wr_data | input | 8 | Byte to enqueue |
| load_pulse | input | 1 | Shift register takes the head byte |
| head_data | output | 8 | Oldest stored byte |
| slot_free | output | 1 | Another write can be accepted |
| tx_irq | output | 1 | Transmit-buffer-empty interrupt level |
| dma_req_n | output | 1 | Active-low DMA transmit request |
| overflow | output | 1 | Sticky flag: a write was dropped |
| underrun | output | 1 | One-cycle flag: a load found the queue empty |

## Verification
The hardest state to reach from the ports is a software reset that must be told apart from the idle state. After a flush the queue looks empty, and the interrupt is then high under either rule, so the select bit cannot be seen directly. The stimulus first selects the room-available rule and stores one byte, so that the interrupt is high with data present. It then issues the software reset and writes a single byte. An interrupt that now drops proves the select bit went back to 1. A load that then reports an underrun proves the flush, and the overflow flag, set earlier, must still read 1.

// File: rtl/txq_pkg.sv
// Shared definitions for the transmit byte queue.
// Assumes: nothing beyond standard SystemVerilog.
package txq_pkg;
    // Trigger rule selected by the mode bit; encoding matches the bit value.
    typedef enum logic {
        TRIG_ROOM  = 1'b0,
        TRIG_EMPTY = 1'b1
    } trig_e;
endpackage

// File: rtl/txq_store.sv
// Circular byte storage with read/write pointers and an occupancy count.
// Writes to a full queue and loads from an empty queue are ignored here;
// the caller observes that through the full/empty flags.
// Assumes: synchronous active-low reset; flush acts like a reset of contents.
module txq_store #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             do_wr, do_rd;

    assign empty   = (count == '0);
    assign full    = (count == FULLC);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rd_ptr];

    // Store accepted bytes at the write pointer.
    always_ff @(posedge clk) begin
        if (do_wr && !flush) mem[wr_ptr] <= wr_data;
    end

    // Advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULLC); // R1
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en && !flush) |=> full); // R5
endmodule

// File: rtl/txq_req_gen.sv
// Derives the interrupt level and the active-low DMA request from the
// queue state and the selected trigger rule. The DMA request is held
// inactive for the cycle after every write so each byte yields an edge.
// Assumes: empty/full come from registered state.
module txq_req_gen
    import txq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  trig_e rule,
    input  logic  empty,
    input  logic  full,
    input  logic  wr_en,
    output logic  irq,
    output logic  dma_req_n
);
    logic trig;
    logic gap_q;

    // Select the trigger condition from the rule.
    always_comb begin
        if (rule == TRIG_EMPTY) trig = empty;
        else                    trig = !full;
    end

    // Remember a write so the DMA request drops for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) gap_q <= 1'b0;
        else        gap_q <= wr_en;
    end

    assign irq       = trig;
    assign dma_req_n = !(trig && !gap_q);

    AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> dma_req_n); // R7
    AST_EMPTY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        (rule == TRIG_EMPTY && !empty) |-> (!irq && dma_req_n)); // R4
endmodule

// File: rtl/txq_top.sv
// Transmit byte queue with selectable request trigger. Holds the mode
// bit, the sticky overflow flag and the underrun pulse, and ties the
// storage to the request generator.
// Assumes: one write and one load at most per cycle; synchronous reset.
module txq_top
    import txq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_reset,
    input  logic             sel_we,
    input  logic             sel_bit,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             load_pulse,
    output logic [WIDTH-1:0] head_data,
    output logic             slot_free,
    output logic             tx_irq,
    output logic             dma_req_n,
    output logic             overflow,
    output logic             underrun
);
    trig_e rule_q;
    logic  empty, full;
    logic  ovf_q, undr_q;

    // Trigger-select bit: reset paths force the fully-empty rule.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_reset) rule_q <= TRIG_EMPTY;
        else if (sel_we)        rule_q <= trig_e'(sel_bit);
    end

    // Sticky overflow on a dropped write; only hardware reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                              ovf_q <= 1'b0;
        else if (wr_en && full && !sw_reset)     ovf_q <= 1'b1;
    end

    // One-cycle underrun after a load that found nothing.
    always_ff @(posedge clk) begin
        if (!rst_n) undr_q <= 1'b0;
        else        undr_q <= load_pulse && empty;
    end

    txq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (sw_reset),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (load_pulse),
        .rd_data (head_data),
        .empty   (empty),
        .full    (full)
    );

    txq_req_gen u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .rule      (rule_q),
        .empty     (empty),
        .full      (full),
        .wr_en     (wr_en),
        .irq       (tx_irq),
        .dma_req_n (dma_req_n)
    );

    assign slot_free = !full;
    assign overflow  = ovf_q;
    assign underrun  = undr_q;

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R5
    AST_UNDERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pulse && empty) |=> underrun); // R6
    AST_SWRST_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (rule_q == TRIG_EMPTY && !tx_irq == 1'b0)); // R2
endmodule

// File: tb/txq_top_bench.sv
// Directed bench for txq_top: one task per scenario, each self-checking.
module txq_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_reset = 1'b0;
    logic       sel_we = 1'b0;
    logic       sel_bit = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       load_pulse = 1'b0;
    logic [7:0] head_data;
    logic       slot_free, tx_irq, dma_req_n, overflow, underrun;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    txq_top u_txq_top (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .sel_we(sel_we),
        .sel_bit(sel_bit), .wr_en(wr_en), .wr_data(wr_data),
        .load_pulse(load_pulse), .head_data(head_data), .slot_free(slot_free),
        .tx_irq(tx_irq), .dma_req_n(dma_req_n), .overflow(overflow),
        .underrun(underrun)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Each helper drives for one cycle starting at a falling edge and
    // returns at the next falling edge, after the registers updated.
    task automatic do_write(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_load();
        @(negedge clk); load_pulse = 1'b1;
        @(negedge clk); load_pulse = 1'b0;
    endtask

    task automatic set_rule(input logic b);
        @(negedge clk); sel_we = 1'b1; sel_bit = b;
        @(negedge clk); sel_we = 1'b0;
    endtask

    task automatic hw_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        hw_reset();
        chk("R3 reset slot_free", slot_free, 1);
        chk("R4 reset irq", tx_irq, 1);
        chk("R7 reset dma", dma_req_n, 0);
        chk("R5 reset ovf", overflow, 0);
        chk("R6 reset underrun", underrun, 0);
    endtask

    task automatic t_empty_rule();
        hw_reset();
        do_write(8'h11);
        chk("R4 rule1 irq with data", tx_irq, 0);
        chk("R7 dma after write", dma_req_n, 1);
        chk("R3 slot_free rule1", slot_free, 1);
        @(negedge clk);
        chk("R4 rule1 dma still off", dma_req_n, 1);
        do_load();
        chk("R4 rule1 irq after drain", tx_irq, 1);
        chk("R4 rule1 dma after drain", dma_req_n, 0);
    endtask

    task automatic t_room_rule_edges();
        hw_reset();
        set_rule(1'b0);
        chk("R4 rule0 irq empty", tx_irq, 1);
        for (int i = 0; i < 3; i++) begin
            do_write(8'h20 + 8'(i));
            chk("R8 dma high after write", dma_req_n, 1);
            chk("R4 rule0 irq with room", tx_irq, 1);
            @(negedge clk);
            chk("R8 dma back low", dma_req_n, 0);
        end
        do_write(8'h23);
        chk("R3 slot_free full", slot_free, 0);
        chk("R4 rule0 irq full", tx_irq, 0);
        @(negedge clk);
        chk("R8 dma stays high full", dma_req_n, 1);
    endtask

    task automatic t_order_overflow_underrun();
        hw_reset();
        do_write(8'hA1); do_write(8'hB2); do_write(8'hC3); do_write(8'hD4);
        chk("R5 ovf before", overflow, 0);
        do_write(8'hE5);
        chk("R5 ovf set", overflow, 1);
        chk("R1 head A", head_data, 8'hA1);
        do_load(); chk("R1 head B", head_data, 8'hB2);
        chk("R3 slot_free after load", slot_free, 1);
        do_load(); chk("R1 head C", head_data, 8'hC3);
        do_load(); chk("R5 head D not E", head_data, 8'hD4);
        do_load();
        chk("R6 no underrun on last real load", underrun, 0);
        chk("R4 empty irq", tx_irq, 1);
        do_load();
        chk("R6 underrun pulse", underrun, 1);
        @(negedge clk);
        chk("R6 underrun single cycle", underrun, 0);
        chk("R5 ovf sticky", overflow, 1);
        // simultaneous write and load on one stored byte
        do_write(8'h55);
        @(negedge clk); wr_en = 1'b1; wr_data = 8'h66; load_pulse = 1'b1;
        @(negedge clk); wr_en = 1'b0; load_pulse = 1'b0;
        chk("R1 write+load head", head_data, 8'h66);
        chk("R6 no underrun on write+load", underrun, 0);
    endtask

    task automatic t_soft_reset();
        hw_reset();
        do_write(8'h77); do_write(8'h78); do_write(8'h79); do_write(8'h7A);
        do_write(8'h7B);
        chk("R5 ovf set again", overflow, 1);
        do_load(); do_load(); do_load();
        set_rule(1'b0);
        chk("R4 rule0 irq with data", tx_irq, 1);
        @(negedge clk); sw_reset = 1'b1; wr_en = 1'b1; wr_data = 8'h99;
        @(negedge clk); sw_reset = 1'b0; wr_en = 1'b0;
        chk("R2 flush wins over write", tx_irq, 1);
        chk("R5 ovf survives sw reset", overflow, 1);
        do_write(8'h42);
        chk("R2 rule back to 1", tx_irq, 0);
        chk("R1 head after flush", head_data, 8'h42);
        do_load();
        do_load();
        chk("R2 flushed queue underrun", underrun, 1);
    endtask

    initial begin
        t_reset_state();
        t_empty_rule();
        t_room_rule_edges();
        t_order_overflow_underrun();
        t_soft_reset();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule